// File: doc/BRIEF.md
# Qubit Coupling Edge Streamer

This block holds an N×N qubit coupling matrix as a flat input vector, where a 1 means the two qubits are coupled and a 0 means they are not. When it accepts a request, it walks the strictly upper triangle of the matrix one entry per clock, in row-major order. Each coupled pair it finds becomes a pair of 10-bit qubit indices. It packs three pairs into each 64-bit response word and sends the words on a valid/ready stream. Because the matrix is symmetric, the upper triangle carries all of it. Entries on or below the diagonal are never read.

A request can ask for the whole triangle or for one row of it. The last word of every answer carries a final flag. An answer with no coupled pair is still exactly one word, with the final flag set. The matrix input must stay stable while a scan is in progress. The block does not decode the opcode or argument fields: the requester sends it only coupling requests.

Top module: `conn_edge_streamer`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: In `req_word`, bit 35 selects single-row mode and bits 34:0 hold the row number. Bits 63:36 are ignored. In whole-matrix mode, bits 34:0 are also ignored.
- R3: Every response word carries the value 3'b100 in bits 63:61 and the final flag in bit 60. It carries slot 0 in bits 59:40, slot 1 in bits 39:20 and slot 2 in bits 19:0. Each slot holds the row index in its upper 10 bits and the column index in its lower 10 bits.
- R4: Only matrix bits (r,c) with c > r are reported, where bit r*N+c of `adj_bits` holds entry (r,c). Bits on or below the diagonal have no effect on the output.
- R5: Pairs appear in row-major order: ascending row, then ascending column. Across words, slot 0 is filled before slot 1, and slot 1 before slot 2.
- R6: Each word holds up to three pairs. Unused slots are zero and appear only after the used slots.
- R7: Only the last word of an answer has the final flag set. Every word before it holds three pairs.
- R8: In single-row mode, only the coupled pairs of the requested row that lie above the diagonal are sent.
- R9: An answer with no qualifying pair is one word with all slots zero and the final flag set. This includes a single-row request for row N-1 or for any row of N or above.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_valid` hold. No pair is lost or repeated.
- R11: `req_ready` is low from the cycle after a request is accepted until the final word has been loaded. The scan covers one entry per clock, so with `rsp_ready` held high the final word's handshake comes M+2 clocks after the accepting edge, where M is the number of entries scanned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adj_bits | input | N*N | Coupling matrix; entry (r,c) at bit r*N+c |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_word | input | 64 | Request word |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Downstream accepts the response word |
| rsp_data | output | 64 | Response word |

## Verification
The case that needs the most care is a fourth coupled pair found during a cycle in which the previous full word is still held by a low `rsp_ready`. In that cycle the scan must freeze without dropping the pair or the held word. The bench provokes this with dense matrices while driving `rsp_ready` with random and mostly-low patterns. It judges the result by comparing every handshaken word against a queue built from a behavioural walk of the matrix, and by checking on every clock that a stalled word does not change. A second case is a new request accepted while the previous final word is still waiting; back-to-back requests under backpressure check that the two answers stay in order.

// File: rtl/conn_edge_streamer.sv
module conn_edge_streamer #(
  parameter int N    = 8,
  parameter int IDXW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*N-1:0] adj_bits,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [63:0]    req_word,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [63:0]    rsp_data
);

  localparam int PAIRW = 2 * IDXW;
  localparam int BUFW  = 3 * PAIRW;
  localparam int AW    = $clog2(N * N);
  localparam logic [2:0]      TAG  = 3'd4;
  localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);
  localparam logic [IDXW-1:0] PENU = IDXW'(N - 2);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FLUSH} st_t;

  st_t             st;
  logic [IDXW-1:0] row, col;
  logic            one_row;
  logic [1:0]      cnt;
  logic [BUFW-1:0] buf_q;

  logic [AW-1:0] pos;
  assign pos = AW'(int'(row) * N + int'(col));

  logic hit, scan_last, can_push, stall;
  assign hit       = adj_bits[pos];
  assign scan_last = (col == LAST) && (one_row || row == PENU);
  assign can_push  = !rsp_valid || rsp_ready;
  assign stall     = !can_push && ((st == S_SCAN && hit && cnt == 2'd3) || st == S_FLUSH);
  assign req_ready = (st == S_IDLE);

  logic        req_one;
  logic [34:0] req_row;
  logic        req_empty;
  assign req_one   = req_word[35];
  assign req_row   = req_word[34:0];
  assign req_empty = req_one ? (req_row >= 35'(N - 1)) : (N < 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      row       <= '0;
      col       <= '0;
      one_row   <= 1'b0;
      cnt       <= '0;
      buf_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          one_row <= req_one;
          row     <= req_one ? IDXW'(req_row) : '0;
          col     <= (req_one ? IDXW'(req_row) : '0) + IDXW'(1);
          cnt     <= '0;
          buf_q   <= '0;
          st      <= req_empty ? S_FLUSH : S_SCAN;
        end
        S_SCAN: if (!stall) begin
          if (hit) begin
            if (cnt == 2'd3) begin
              rsp_data  <= {TAG, 1'b0, buf_q};
              rsp_valid <= 1'b1;
              buf_q     <= {row, col, {(BUFW-PAIRW){1'b0}}};
              cnt       <= 2'd1;
            end else begin
              buf_q[(BUFW-1) - int'(cnt)*PAIRW -: PAIRW] <= {row, col};
              cnt <= cnt + 2'd1;
            end
          end
          if (scan_last) begin
            st <= S_FLUSH;
          end else if (col == LAST) begin
            row <= row + IDXW'(1);
            col <= row + IDXW'(2);
          end else begin
            col <= col + IDXW'(1);
          end
        end
        S_FLUSH: if (can_push) begin
          rsp_data  <= {TAG, 1'b1, buf_q};
          rsp_valid <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  function automatic logic pair_ok(input logic [PAIRW-1:0] p);
    return (p == '0) || ((p[PAIRW-1:IDXW] < p[IDXW-1:0]) && (p[IDXW-1:0] <= LAST));
  endfunction

  AST_TAG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_data[63:61] == 3'b100); // R3
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R10
  AST_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> pair_ok(rsp_data[59:40]) && pair_ok(rsp_data[39:20]) && pair_ok(rsp_data[19:0])); // R4
  AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_data[39:20] == '0 |-> rsp_data[19:0] == '0 && (rsp_data[59:40] != '0 || rsp_data[60])); // R6
  AST_NONFINAL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_data[60] |-> rsp_data[19:0] != '0); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R11

endmodule

// File: tb/conn_edge_streamer_tb.sv
module conn_edge_streamer_tb;
  localparam int N = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [N*N-1:0] adj_bits = '0;
  logic req_valid = 0;
  logic [63:0] req_word = '0;
  logic req_ready, rsp_valid, rsp_ready, rsp_data_dummy;
  logic [63:0] rsp_data;

  conn_edge_streamer #(.N(N), .IDXW(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .adj_bits(adj_bits), .req_valid(req_valid),
    .req_ready(req_ready), .req_word(req_word), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, mode = 0, last_final_cyc = 0;
  logic [63:0] expq[$];
  logic pv = 0, pr = 0;
  logic [63:0] pd = '0;
  bit done = 0;

  assign rsp_data_dummy = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: behavioural walk of the upper triangle (R4 R5 R6 R7 R8 R9)
  task automatic build(input logic [N*N-1:0] m, input bit one, input int rowsel);
    int k = 0;
    logic [59:0] b = '0;
    for (int r = 0; r < N; r++)
      for (int c = r + 1; c < N; c++)
        if ((!one || r == rowsel) && m[r*N+c]) begin
          if (k == 3) begin expq.push_back({3'b100, 1'b0, b}); b = '0; k = 0; end
          b[59 - k*20 -: 20] = {10'(r), 10'(c)};
          k++;
        end
    expq.push_back({3'b100, 1'b1, b});
  endtask

  initial rsp_ready = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr) chk(rsp_valid && rsp_data == pd, "R10 hold", rsp_data, pd);
      case (mode)
        0: rsp_ready = 1;
        1: rsp_ready = $urandom % 2;
        default: rsp_ready = ($urandom % 4) == 0;
      endcase
      if (rsp_valid && rsp_ready) begin
        if (expq.size() == 0) chk(0, "R7 extra word", rsp_data, 64'h0);
        else begin
          logic [63:0] e;
          e = expq.pop_front();
          chk(rsp_data == e, "R3 R5 R6 R7 word", rsp_data, e);
          if (rsp_data[60]) last_final_cyc = cyc;
        end
      end
      pv = rsp_valid; pr = rsp_ready; pd = rsp_data;
    end
  end

  task automatic run(input logic [N*N-1:0] m, input bit one, input logic [34:0] rowf,
                     input logic [27:0] hi, input int md, input int scan_cnt, input string tag);
    int acc, wait_n;
    @(negedge clk);
    adj_bits = m; mode = md;
    build(m, one, (rowf < 35'(N)) ? int'(rowf) : -1);
    wait_n = 0;
    while (!req_ready && wait_n < 5000) begin @(negedge clk); wait_n++; end
    req_valid = 1; req_word = {hi, one, rowf};
    acc = cyc;
    @(negedge clk);
    req_valid = 0;
    wait_n = 0;
    while (!(expq.size() == 0 && req_ready && !rsp_valid) && wait_n < 5000) begin
      @(negedge clk); wait_n++;
    end
    chk(expq.size() == 0, {tag, " all words seen"}, 64'(expq.size()), 64'h0);
    if (md == 0 && scan_cnt >= 0)
      chk(last_final_cyc - acc == scan_cnt + 2, {"R11 latency ", tag},
          64'(last_final_cyc - acc), 64'(scan_cnt + 2));
    expq.delete();
  endtask

  function automatic logic [N*N-1:0] lower_junk();
    logic [N*N-1:0] v = '0;
    for (int r = 0; r < N; r++) for (int c = 0; c <= r; c++) v[r*N+c] = 1'b1;
    return v;
  endfunction

  initial begin
    logic [N*N-1:0] m;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && req_ready, "R1 reset state", {62'h0, rsp_valid, req_ready}, 64'h1);
    rst_n = 1;
    // R9 empty matrix, whole mode
    run('0, 0, 35'h0, 28'h0, 0, 28, "R9 empty");
    // R4 only lower triangle and diagonal set: no pairs
    run(lower_junk(), 0, 35'h0, 28'h0, 0, 28, "R4 lower ignored");
    // full matrix, R2 garbage in ignored fields
    run('1, 0, 35'h5A5A5, 28'hABCDEF1, 0, 28, "R2 R5 full");
    run('1, 0, 35'h0, 28'h0, 1, -1, "R10 full random ready");
    run('1, 0, 35'h0, 28'h0, 2, -1, "R10 full slow ready");
    // R8 single rows
    run('1, 1, 35'd0, 28'h0, 0, 7, "R8 row0");
    run('1, 1, 35'd6, 28'hFFFFFFF, 0, 1, "R8 row6");
    run('1, 1, 35'd3, 28'h0, 2, -1, "R8 row3 slow");
    run('1, 1, 35'd7, 28'h0, 0, 0, "R9 last row");
    run('1, 1, 35'd100, 28'h0, 0, 0, "R9 row out of range");
    // sparse: exactly three pairs in one final word (R6 R7)
    m = '0; m[0*N+5] = 1; m[2*N+3] = 1; m[6*N+7] = 1;
    run(m | lower_junk(), 0, 35'h0, 28'h0, 0, 28, "R6 three pairs");
    m[4*N+6] = 1;
    run(m, 0, 35'h0, 28'h0, 1, -1, "R7 four pairs");
    for (int i = 0; i < 12; i++) begin
      m = {$urandom, $urandom};
      run(m, i % 3 == 0, 35'(i % 9), 28'($urandom), i % 3, -1, "R5 random");
    end
    // back-to-back under backpressure: second request while final word waits
    @(negedge clk);
    adj_bits = '1; mode = 2;
    build('1, 1, 5);
    build('1, 1, 4);
    req_valid = 1; req_word = {28'h0, 1'b1, 35'd5};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_word = {28'h0, 1'b1, 35'd4};
    @(negedge clk);
    req_valid = 0;
    for (int w = 0; w < 3000 && !(expq.size() == 0 && req_ready && !rsp_valid); w++) @(negedge clk);
    chk(expq.size() == 0, "R10 R11 back-to-back", 64'(expq.size()), 64'h0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hang expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule